// File: doc/BRIEF.md
# Shared-Bus Configuration Register Port

This block gives a host access to a small bank of on-chip configuration registers over one 10-bit bus that carries the address and the data in turn. Each access takes two toggles of a slow access clock. The first toggle captures a register address and the second moves the data. A select line routes the bus either to this port or to an ancillary path. A direction line chooses between a write and a read.

The access clock is sampled by the fast system clock, and only its rising transitions count. One register holds the pattern and self-test controls. It drives the pattern code, the filter enable and the test enable straight to the pattern generator. When that register is read, one of its bits shows the live pass/fail result from the self-test rather than a stored value.

The bus is split into an input, an output and an output enable so that the pad tristate can sit outside the block.

Top module: `ctl_reg_port`

## Requirements
- R1: After reset, test_en is 0, filt_en is 0 and pat_sel equals the 525-line 270 Mb/s default code 0x01. Reading the test register then returns 0x001 with bit 7 taken from pass_in.
- R2: A toggle taken while sel_anc is high is ignored. It latches nothing, writes nothing and does not advance the address/data phase.
- R3: The first qualified toggle latches bus_in[9:0] as the register address. The second qualified toggle is the data phase. After the data phase the port waits for a new address phase.
- R4: A data phase with rd_wr low writes bus_in into the addressed register. The register reads back the same value.
- R5: A data phase with rd_wr high places the addressed register's contents on bus_out and raises bus_oe. bus_oe falls on the first clock after rd_wr goes low.
- R6: The test register sits at address 0x00D. Its fields are: bits [5:0] pattern code (pat_sel), bit 6 filter enable (filt_en), bit 7 read-only pass/fail, bit 8 test enable (test_en) and bit 9 a spare read/write bit. The outputs follow the stored fields.
- R7: Writing 0x343 to address 0x00D selects pattern code 0x03 (525-line colour bars), turns the filter on and starts the test (test_en = 1).
- R8: Bit 7 of the test register always reads the current value of pass_in. A write to bit 7 is ignored.
- R9: An address at or above NUM_REGS (16) holds no register. A write to it is ignored and a read from it returns zero.
- R10: The access clock counts once per rising transition. Holding acc_clk high for many system clocks yields a single toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_clk | input | 1 | Access clock; rising transitions step the port |
| sel_anc | input | 1 | High routes the bus to the ancillary path (port ignores toggles) |
| rd_wr | input | 1 | High for read, low for write |
| bus_in | input | 10 | Address or write data from the shared bus |
| bus_out | output | 10 | Read data toward the shared bus |
| bus_oe | output | 1 | Enables bus_out onto the shared bus |
| pass_in | input | 1 | Live pass/fail status from the self-test |
| test_en | output | 1 | Test/pattern generator enable |
| filt_en | output | 1 | Colour-bar filter enable |
| pat_sel | output | 6 | Selected test pattern code |

## Verification
On every cycle, the assertions check four things: a write never happens while the ancillary select is high or the direction is read; the control outputs stay frozen on cycles where the ancillary select is high; the output enable rises only after a qualified read and drops once the direction returns low; and reset restores the defaults. Other properties can only be shown by the scoreboard scenarios: the two-phase ordering, that ignored toggles do not advance the phase, the read-back of stored values, the live pass/fail merge and the masking of its bit, and the silence of unused addresses.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  typedef enum logic {PH_ADDR, PH_DATA} phase_t;

  // Bit positions inside the test register; the outputs decode these.
  localparam int FILT_BIT = 6;
  localparam int PF_BIT   = 7;
  localparam int EN_BIT   = 8;
endpackage

// File: rtl/acc_edge.sv
module acc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_clk,
  output logic tog
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      tog <= 1'b0;
    end else begin
      sh  <= {sh[SH_W-2:0], acc_clk};
      tog <= sh[SH_W-2] & ~sh[SH_W-1];
    end
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import ctl_pkg::*;
#(
  parameter int BUS_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tog,
  input  logic             sel_anc,
  input  logic             rd_wr,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] addr_q,
  output logic             wr_en,
  output logic             rd_en
);
  phase_t ph;
  logic   step;

  assign step  = tog & ~sel_anc;
  assign wr_en = step & (ph == PH_DATA) & ~rd_wr;
  assign rd_en = step & (ph == PH_DATA) & rd_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_ADDR;
      addr_q <= '0;
    end else if (step) begin
      if (ph == PH_ADDR) begin
        addr_q <= bus_in;
        ph     <= PH_DATA;
      end else begin
        ph     <= PH_ADDR;
      end
    end
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import ctl_pkg::*;
#(
  parameter int BUS_W     = 10,
  parameter int NUM_REGS  = 16,
  parameter int TEST_ADDR = 13,
  parameter int PAT_W     = 6,
  parameter int PAT_DEF   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             pass_in,
  output logic [BUS_W-1:0] rd_word,
  output logic [BUS_W-1:0] test_word
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [BUS_W-1:0] TEST_RST = BUS_W'(PAT_DEF);
  localparam logic [BUS_W-1:0] PF_MASK  = ~(BUS_W'(1) << PF_BIT);

  logic [BUS_W-1:0] regs [NUM_REGS];
  logic             hit;
  logic             is_test;
  logic [IDX_W-1:0] idx;

  assign hit     = (addr < BUS_W'(NUM_REGS));
  assign is_test = (addr == BUS_W'(TEST_ADDR));
  assign idx     = addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [BUS_W-1:0] RVAL = (g == TEST_ADDR) ? TEST_RST : '0;
    localparam logic [BUS_W-1:0] WMSK = (g == TEST_ADDR) ? PF_MASK : '1;
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= RVAL;
      else if (wr_en && hit && idx == IDX_W'(g))
        regs[g] <= wr_data & WMSK;
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit) rd_word = regs[idx];
    if (is_test) rd_word[PF_BIT] = pass_in;
  end

  assign test_word = regs[TEST_ADDR];
endmodule

// File: rtl/ctl_reg_port.sv
module ctl_reg_port
  import ctl_pkg::*;
#(
  parameter int BUS_W       = 10,
  parameter int NUM_REGS    = 16,
  parameter int TEST_ADDR   = 13,
  parameter int PAT_W       = 6,
  parameter int PAT_DEF     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_clk,
  input  logic             sel_anc,
  input  logic             rd_wr,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe,
  input  logic             pass_in,
  output logic             test_en,
  output logic             filt_en,
  output logic [PAT_W-1:0] pat_sel
);
  logic             tog;
  logic             wr_en;
  logic             rd_en;
  logic [BUS_W-1:0] addr_q;
  logic [BUS_W-1:0] rd_word;
  logic [BUS_W-1:0] test_word;

  acc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .acc_clk(acc_clk), .tog(tog)
  );

  acc_seq #(.BUS_W(BUS_W)) u_seq (
    .clk(clk), .rst(rst), .tog(tog), .sel_anc(sel_anc), .rd_wr(rd_wr),
    .bus_in(bus_in), .addr_q(addr_q), .wr_en(wr_en), .rd_en(rd_en)
  );

  reg_bank #(
    .BUS_W(BUS_W), .NUM_REGS(NUM_REGS), .TEST_ADDR(TEST_ADDR),
    .PAT_W(PAT_W), .PAT_DEF(PAT_DEF)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr_q), .wr_data(bus_in),
    .pass_in(pass_in), .rd_word(rd_word), .test_word(test_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
    end else if (rd_en) begin
      bus_out <= rd_word;
      bus_oe  <= 1'b1;
    end else if (!rd_wr) begin
      bus_oe  <= 1'b0;
    end
  end

  assign test_en = test_word[EN_BIT];
  assign filt_en = test_word[FILT_BIT];
  assign pat_sel = test_word[PAT_W-1:0];
endmodule

// File: rtl/ctl_reg_port_chk.sv
module ctl_reg_port_chk #(
  parameter int PAT_W   = 6,
  parameter int PAT_DEF = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_anc,
  input logic             rd_wr,
  input logic             bus_oe,
  input logic             wr_en,
  input logic             test_en,
  input logic             filt_en,
  input logic [PAT_W-1:0] pat_sel
);
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!test_en && !filt_en && pat_sel == PAT_W'(PAT_DEF))); // R1

  AST_ANC_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (sel_anc && !rst) |=> $stable({test_en, filt_en, pat_sel})); // R2

  AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!sel_anc && !rd_wr)); // R4

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> ($past(rd_wr) && !$past(sel_anc))); // R5

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !rd_wr |=> !bus_oe); // R5
endmodule

bind ctl_reg_port ctl_reg_port_chk #(.PAT_W(PAT_W), .PAT_DEF(PAT_DEF)) u_chk (
  .clk(clk), .rst(rst), .sel_anc(sel_anc), .rd_wr(rd_wr), .bus_oe(bus_oe),
  .wr_en(wr_en), .test_en(test_en), .filt_en(filt_en), .pat_sel(pat_sel)
);

// File: tb/test_ctl_reg_port.sv
module test_ctl_reg_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_clk = 1'b0;
  logic       sel_anc = 1'b0;
  logic       rd_wr = 1'b0;
  logic [9:0] bus_in = '0;
  logic       pass_in = 1'b0;
  logic [9:0] bus_out;
  logic       bus_oe;
  logic       test_en;
  logic       filt_en;
  logic [5:0] pat_sel;

  int checks = 0;
  int errors = 0;

  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic       oe_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_reg_port i_ctl_reg_port (
    .clk(clk), .rst(rst), .acc_clk(acc_clk), .sel_anc(sel_anc), .rd_wr(rd_wr),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .pass_in(pass_in),
    .test_en(test_en), .filt_en(filt_en), .pat_sel(pat_sel)
  );

  task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic toggle(input int high_cyc);
    @(negedge clk) acc_clk = 1'b1;
    repeat (high_cyc) @(negedge clk);
    acc_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_reg(input logic [9:0] a, input logic [9:0] d);
    @(negedge clk); sel_anc = 1'b0; rd_wr = 1'b0; bus_in = a;
    toggle(4);
    bus_in = d;
    toggle(4);
  endtask

  task automatic read_reg(input logic [9:0] a, input logic [9:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk); sel_anc = 1'b0; rd_wr = 1'b0; bus_in = a;
    toggle(4);
    rd_wr = 1'b1; bus_in = 10'h2AA;
    toggle(4);
    rd_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: each new output-enable pulse is one read result.
  always @(negedge clk) begin
    if (bus_oe && !oe_d) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected read got %h expected none", bus_out);
      end else begin
        chk(tag_q.pop_front(), bus_out, exp_q.pop_front());
      end
    end
    oe_d <= bus_oe;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 test_en", {9'd0, test_en}, 10'd0);
    chk("R1 filt_en", {9'd0, filt_en}, 10'd0);
    chk("R1 pat_sel", {4'd0, pat_sel}, 10'h001);
    chk("R5 bus_oe idle", {9'd0, bus_oe}, 10'd0);
    read_reg(10'h00D, 10'h001, "R1 test reg default");

    // R4 / R3 plain write then read-back
    write_reg(10'h002, 10'h155);
    read_reg(10'h002, 10'h155, "R4 readback reg2");
    write_reg(10'h00F, 10'h2AB);
    read_reg(10'h00F, 10'h2AB, "R3 readback reg15");

    // R7 / R6 start test with colour bars
    write_reg(10'h00D, 10'h343);
    chk("R7 test_en", {9'd0, test_en}, 10'd1);
    chk("R7 pat_sel", {4'd0, pat_sel}, 10'h003);
    chk("R6 filt_en", {9'd0, filt_en}, 10'd1);
    read_reg(10'h00D, 10'h343, "R6 test reg pass=0");
    pass_in = 1'b1;
    read_reg(10'h00D, 10'h3C3, "R8 test reg pass=1");

    // R8 bit 7 write ignored
    pass_in = 1'b0;
    write_reg(10'h00D, 10'h3FF);
    read_reg(10'h00D, 10'h37F, "R8 pf bit not stored");
    chk("R6 pat_sel all ones", {4'd0, pat_sel}, 10'h03F);

    // R9 unused address
    write_reg(10'h020, 10'h3FF);
    read_reg(10'h020, 10'h000, "R9 unused reads zero");
    read_reg(10'h3FF, 10'h000, "R9 top address zero");

    // R2 ancillary-select toggles ignored and do not advance phase
    @(negedge clk); sel_anc = 1'b1; rd_wr = 1'b0; bus_in = 10'h005;
    toggle(4);
    bus_in = 10'h111;
    toggle(4);
    bus_in = 10'h00D;
    toggle(4);
    sel_anc = 1'b0;
    chk("R2 pat_sel unchanged", {4'd0, pat_sel}, 10'h03F);
    read_reg(10'h005, 10'h000, "R2 reg5 untouched");
    // Next qualified toggle must be an address phase
    write_reg(10'h004, 10'h0F0);
    read_reg(10'h004, 10'h0F0, "R3 phase restarted");

    // R10 long-held access clock counts once
    @(negedge clk); sel_anc = 1'b0; rd_wr = 1'b0; bus_in = 10'h006;
    toggle(40);
    bus_in = 10'h099;
    toggle(40);
    read_reg(10'h006, 10'h099, "R10 long high single toggle");

    // R5 oe drops after rd_wr low
    chk("R5 bus_oe released", {9'd0, bus_oe}, 10'd0);

    // Back to the colour-bar setting
    write_reg(10'h00D, 10'h343);
    chk("R7 pat_sel again", {4'd0, pat_sel}, 10'h003);

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 missing reads got %0d pending expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule